// File: doc/BRIEF.md
# Divided Serial Clock Generator

This block turns a fast system clock into the bit timing for a serial shift engine. It drives a serial clock level (`sclk_o`) and two one-cycle strobes. `drive_o` tells the shift engine to put out the next data bit. `sample_o` tells it to capture the incoming bit. The clock rate comes from a base tick and a 16-bit divisor. The base tick runs either on every system clock or on every fifth one. Each half period of the serial clock lasts divisor + 1 base ticks, so the serial clock runs at base / ((1 + divisor) × 2).

Two optional modes change the bit sequence. In three-phase mode every bit takes three half periods: a low half, a high half, and an extra low half. Sampling happens on the falling edge. Driving happens at the end of the extra low half, so the data stays valid across the additional half period. In adaptive mode the generator holds the clock high after each rising edge. It waits until an external return-clock pin, passed through a two-flop synchronizer, reads high, and only then counts out the high half.

The configuration inputs are captured only while the generator is stopped (`run_i` low). Changes made during a transfer therefore never disturb it. Dropping `run_i` stops the generator at once and returns the clock to its low idle level.

Top module: `serclk_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `sclk_o`, `drive_o` and `sample_o` are all 0.
- R2: Reset loads these settings: two-phase, non-adaptive, fast base, divisor 0. They stay in force until the first cycle in which `run_i` is low, even if the configuration inputs hold other values.
- R3: With the fast base selected (`slow_base_i`=0), a base tick occurs on every system clock. Each half period lasts divisor+1 ticks, so the first rising edge of `sclk_o` comes divisor+1 cycles after `run_i` rises.
- R4: With `slow_base_i`=1, a base tick occurs once every 5 system clocks. Each half period then lasts 5×(divisor+1) cycles.
- R5: In two-phase mode (`tri_phase_i`=0), each rising edge of `sclk_o` comes with a `sample_o` pulse and each falling edge with a `drive_o` pulse. One period spans two half periods.
- R6: In three-phase mode (`tri_phase_i`=1), the order is: rising edge with no strobe, falling edge with `sample_o`, one more low half period, then `drive_o` with no clock edge. One period spans three half periods.
- R7: In adaptive mode (`adaptive_i`=1), after a rising edge `sclk_o` stays high while the synchronized return pin reads 0. Once `ret_pin_i` goes high, two synchronizer stages pass, and then the high half period (divisor+1 ticks) is counted.
- R8: The divisor, base select and mode bits are captured only in cycles where `run_i` is low. Changing them while running has no effect on the transfer in progress.
- R9: When `run_i` is low, the next cycle shows `sclk_o`=0 with both strobes 0, and all counts restart. A new run behaves exactly like the first one.
- R10: `drive_o` and `sample_o` never pulse in the same cycle. `drive_o` only pulses while `sclk_o` is 0.
- R11: The largest divisor, 65535, gives a half period of 65536 base ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | 1 runs the generator, 0 stops it and captures configuration |
| div_i | input | 16 | Half-period divisor; half period = div_i+1 base ticks |
| slow_base_i | input | 1 | 1 selects the base tick at one fifth of the system clock |
| tri_phase_i | input | 1 | 1 selects three-phase data clocking |
| adaptive_i | input | 1 | 1 makes the high phase wait for the return pin |
| ret_pin_i | input | 1 | Asynchronous return-clock pin |
| sclk_o | output | 1 | Serial clock level, idles low |
| drive_o | output | 1 | One-cycle strobe: drive next data bit |
| sample_o | output | 1 | One-cycle strobe: capture input bit |

## Verification
Two events can fall in the same cycle: a configuration change and an active half-period count. The bench provokes this by changing the divisor just after a rising edge. It judges the result by the next rising edge, which must still arrive on the old schedule, and by the following run, which must adopt the new rate. A second overlap is between the adaptive stall and the return pin going high. The bench releases the pin at a known cycle. The falling edge must then appear exactly three cycles later, and the clock must not change before that.

// File: rtl/serclk_pkg.sv
package serclk_pkg;
  // Position of the serial clock inside one bit time
  typedef enum logic [1:0] {
    PH_LOW  = 2'd0,
    PH_HIGH = 2'd1,
    PH_HOLD = 2'd2
  } phase_t;
endpackage

// File: rtl/serclk_sync.sv
module serclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/serclk_prescale.sv
module serclk_prescale #(
  parameter int RATIO = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic slow,
  output logic tick
);
  localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;

  generate
    if (RATIO > 1) begin : g_div
      logic [CW-1:0] cnt;
      logic          wrap;
      assign wrap = (cnt == CW'(RATIO - 1));
      always_ff @(posedge clk) begin
        if (rst || !run)   cnt <= '0;
        else if (slow)     cnt <= wrap ? '0 : cnt + 1'b1;
      end
      assign tick = run && (!slow || wrap);
    end else begin : g_nodiv
      assign tick = run;
    end
  endgenerate
endmodule

// File: rtl/serclk_halfcnt.sv
module serclk_halfcnt #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             adv,
  input  logic [DIV_W-1:0] limit,
  output logic             hp_end
);
  logic [DIV_W-1:0] cnt;
  logic             step;
  logic             last;

  assign step = run && tick && adv;
  assign last = (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (step)    cnt <= last ? '0 : cnt + 1'b1;
  end

  assign hp_end = step && last;
endmodule

// File: rtl/serclk_gen.sv
module serclk_gen #(
  parameter int DIV_W      = 16,
  parameter int SLOW_RATIO = 5,
  parameter int SYNC_STG   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             slow_base_i,
  input  logic             tri_phase_i,
  input  logic             adaptive_i,
  input  logic             ret_pin_i,
  output logic             sclk_o,
  output logic             drive_o,
  output logic             sample_o
);
  import serclk_pkg::*;

  // Captured configuration
  logic [DIV_W-1:0] div_q;
  logic             slow_q;
  logic             tri_q;
  logic             adapt_q;

  logic   ret_s;
  logic   tick;
  logic   hp_end;
  logic   adv_en;
  phase_t ph;

  serclk_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (ret_pin_i),
    .q   (ret_s)
  );

  serclk_prescale #(.RATIO(SLOW_RATIO)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .run  (run_i),
    .slow (slow_q),
    .tick (tick)
  );

  // High phase is frozen in adaptive mode until the return pin is seen high
  assign adv_en = !(adapt_q && (ph == PH_HIGH) && !ret_s);

  serclk_halfcnt #(.DIV_W(DIV_W)) u_half (
    .clk    (clk),
    .rst    (rst),
    .run    (run_i),
    .tick   (tick),
    .adv    (adv_en),
    .limit  (div_q),
    .hp_end (hp_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_LOW;
      sclk_o   <= 1'b0;
      sample_o <= 1'b0;
      drive_o  <= 1'b0;
      div_q    <= '0;
      slow_q   <= 1'b0;
      tri_q    <= 1'b0;
      adapt_q  <= 1'b0;
    end else begin
      sample_o <= 1'b0;
      drive_o  <= 1'b0;
      if (!run_i) begin
        ph      <= PH_LOW;
        sclk_o  <= 1'b0;
        div_q   <= div_i;
        slow_q  <= slow_base_i;
        tri_q   <= tri_phase_i;
        adapt_q <= adaptive_i;
      end else if (hp_end) begin
        unique case (ph)
          PH_LOW: begin
            ph       <= PH_HIGH;
            sclk_o   <= 1'b1;
            sample_o <= !tri_q;
          end
          PH_HIGH: begin
            sclk_o <= 1'b0;
            if (tri_q) begin
              ph       <= PH_HOLD;
              sample_o <= 1'b1;
            end else begin
              ph      <= PH_LOW;
              drive_o <= 1'b1;
            end
          end
          PH_HOLD: begin
            ph      <= PH_LOW;
            drive_o <= 1'b1;
          end
          default: ph <= PH_LOW;
        endcase
      end
    end
  end
endmodule

// File: rtl/serclk_gen_chk.sv
module serclk_gen_chk (
  input logic clk,
  input logic rst,
  input logic run_i,
  input logic sclk_o,
  input logic drive_o,
  input logic sample_o,
  input logic adapt_q,
  input logic ret_s
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(drive_o && sample_o)); // R10

  AST_DRIVE_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
    drive_o |-> !sclk_o); // R5

  AST_SAMPLE_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    sample_o |-> (sclk_o != $past(sclk_o))); // R6

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (!sclk_o && !drive_o && !sample_o)); // R9

  AST_ADAPT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (run_i && adapt_q && sclk_o && !ret_s) |=> sclk_o); // R7
endmodule

bind serclk_gen serclk_gen_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .run_i    (run_i),
  .sclk_o   (sclk_o),
  .drive_o  (drive_o),
  .sample_o (sample_o),
  .adapt_q  (adapt_q),
  .ret_s    (ret_s)
);

// File: tb/serclk_gen_tb_top.sv
module serclk_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {divisor[17:2], slow base[1], three-phase[0]}
  localparam logic [17:0] VECS [NVEC] = '{
    {16'd0, 2'b00},
    {16'd3, 2'b00},
    {16'd0, 2'b10},
    {16'd2, 2'b01},
    {16'd1, 2'b11},
    {16'd6, 2'b00}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_i = 1'b0;
  logic [15:0] div_i = '0;
  logic        slow_base_i = 1'b0;
  logic        tri_phase_i = 1'b0;
  logic        adaptive_i = 1'b0;
  logic        ret_pin_i = 1'b0;
  logic        sclk_o, drive_o, sample_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serclk_gen dut_i (
    .clk         (clk),
    .rst         (rst),
    .run_i       (run_i),
    .div_i       (div_i),
    .slow_base_i (slow_base_i),
    .tri_phase_i (tri_phase_i),
    .adaptive_i  (adaptive_i),
    .ret_pin_i   (ret_pin_i),
    .sclk_o      (sclk_o),
    .drive_o     (drive_o),
    .sample_o    (sample_o)
  );

  task automatic chk(input string req, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic go_idle(input int n);
    run_i = 1'b0;
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    int h, f_rise, s_rise, f_samp, f_drv, idx;
    logic prev;
    // R1: reset state
    run_i = 1'b1; tri_phase_i = 1'b1; slow_base_i = 1'b1; div_i = 16'd4; adaptive_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 sclk in reset", sclk_o, 0);
    chk("R1 strobes in reset", drive_o | sample_o, 0);
    rst = 1'b0;
    // R2: defaults stay while run held high
    @(negedge clk);
    chk("R2 rise at 1", sclk_o, 1);
    chk("R2 sample at 1", sample_o, 1);
    @(negedge clk);
    chk("R2 drive at 2", drive_o, 1);
    @(negedge clk);
    chk("R2 rise at 3", sclk_o, 1);

    // Vector table
    adaptive_i = 1'b0;
    for (int v = 0; v < NVEC; v++) begin
      go_idle(3);
      div_i = VECS[v][17:2]; slow_base_i = VECS[v][1]; tri_phase_i = VECS[v][0];
      @(negedge clk);
      h = (int'(VECS[v][17:2]) + 1) * (VECS[v][1] ? 5 : 1);
      f_rise = 0; s_rise = 0; f_samp = 0; f_drv = 0; prev = 1'b0;
      run_i = 1'b1;
      for (int i = 1; i <= 8*h; i++) begin
        @(negedge clk);
        if (sclk_o && !prev) begin
          if (f_rise == 0) f_rise = i;
          else if (s_rise == 0) s_rise = i;
        end
        if (sample_o && f_samp == 0) f_samp = i;
        if (drive_o && f_drv == 0) f_drv = i;
        prev = sclk_o;
      end
      chk(VECS[v][1] ? "R4 first rise" : "R3 first rise", f_rise, h);
      if (VECS[v][0]) begin
        chk("R6 second rise", s_rise, 4*h);
        chk("R6 sample at fall", f_samp, 2*h);
        chk("R6 drive after hold", f_drv, 3*h);
      end else begin
        chk("R5 second rise", s_rise, 3*h);
        chk("R5 sample at rise", f_samp, h);
        chk("R5 drive at fall", f_drv, 2*h);
      end
    end

    // R8: divisor change while running is ignored
    go_idle(3);
    div_i = 16'd1; slow_base_i = 1'b0; tri_phase_i = 1'b0;
    @(negedge clk);
    run_i = 1'b1;
    s_rise = 0; prev = 1'b0;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      if (i == 2) begin
        chk("R8 first rise", sclk_o, 1);
        div_i = 16'd5;
      end
      if (i == 6) chk("R8 second rise on old rate", sclk_o, 1);
    end
    // R9: stop returns clock low
    run_i = 1'b0;
    @(negedge clk);
    chk("R9 clock low after stop", sclk_o, 0);
    chk("R9 strobes quiet after stop", drive_o | sample_o, 0);
    @(negedge clk);
    run_i = 1'b1;
    idx = 0; prev = 1'b0;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      if (sclk_o && !prev && idx == 0) idx = i;
      prev = sclk_o;
    end
    chk("R8 new divisor after idle", idx, 6);

    // R7: adaptive stall
    go_idle(3);
    div_i = 16'd0; adaptive_i = 1'b1; ret_pin_i = 1'b0;
    @(negedge clk);
    run_i = 1'b1;
    f_drv = 0;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      if (drive_o) f_drv++;
    end
    chk("R7 held high", sclk_o, 1);
    chk("R7 no drive while held", f_drv, 0);
    ret_pin_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R7 still high before sync", sclk_o, 1);
    @(negedge clk);
    chk("R7 falls after sync", sclk_o, 0);
    chk("R7 drive at fall", drive_o, 1);
    chk("R10 no overlap", drive_o & sample_o, 0);
    @(negedge clk);
    chk("R7 rises again", sclk_o, 1);
    @(negedge clk);
    chk("R7 falls with pin high", sclk_o, 0);

    // R11: largest divisor
    go_idle(3);
    div_i = 16'hFFFF; adaptive_i = 1'b0; ret_pin_i = 1'b0;
    @(negedge clk);
    run_i = 1'b1;
    idx = 0;
    for (int i = 1; i <= 70000 && idx == 0; i++) begin
      @(negedge clk);
      if (sclk_o) idx = i;
    end
    chk("R11 max divisor half period", idx, 65536);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 200000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule